// File: doc/BRIEF.md
# Hysteresis Window Filter for a Sampled Serial Line

This block cleans up a slow open-drain serial line, such as an I2C clock or data wire, after the line has been brought into the system clock domain. Slow edges can pass through the logic threshold many times within a few hundred nanoseconds. The filter takes one sample of the line on every clock. It keeps the most recent `WIN` samples in a shift window and tracks how many of them are ones.

The filtered level works like a Schmitt trigger. It goes high only once the ones count reaches `RISE_TH`, and it goes low only once the count drops to `FALL_TH` or below. For any count between the two thresholds the level keeps its value. A glitch that lands late in a transition can move the count back across one threshold, but it cannot reach the other threshold. Each clean edge therefore gives one output change. The count is updated incrementally: each cycle it adds the bit entering the window and removes the bit leaving it.

Top module: `glitch_window_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `level_o` is 1 and `ones_o` equals `WIN`. The window counts as filled with ones.
- R2: One cycle after each clock edge, `ones_o` equals the number of ones among the last `WIN` values of `line_i` sampled at that edge and the edges before it. Samples from before reset count as ones.
- R3: `ones_o` never exceeds `WIN`.
- R4: `ones_o` changes by at most one between consecutive cycles.
- R5: `level_o` becomes 1 one cycle after a cycle in which `ones_o >= RISE_TH`. It never rises in any other case.
- R6: `level_o` becomes 0 one cycle after a cycle in which `ones_o <= FALL_TH`. It never falls in any other case.
- R7: When `FALL_TH < ones_o < RISE_TH`, `level_o` keeps its value in the next cycle.
- R8: Take a level change of `line_i` that has a glitch burst of fewer than min(`RISE_TH`, `WIN-FALL_TH`) samples just after it, followed by a stable level held for at least `WIN` samples. This produces exactly one change of `level_o`.
- R9: A burst longer than the window may cause several changes of `level_o`. In every cycle the output still follows R5 to R7 applied to the count of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| line_i | input | 1 | Line level, already synchronized to `clk_i` |
| level_o | output | 1 | Filtered line level |
| ones_o | output | $clog2(WIN+1) | Number of ones currently in the sample window |

## Verification
The bench builds the block with its defaults: `WIN=32`, `RISE_TH=24` and `FALL_TH=8`. With these values the count can reach its full value of 32 and fall to zero. A burst of up to 20 samples is short enough to count as short, and an 80-sample burst is longer than the window. A reference model in the bench recomputes the count and the level every cycle. The directed cases cover an alternating pattern that holds the count between the thresholds and a late glitch inside a run of ones. Random bursts of random length and content fill in the cases between them.

// File: rtl/gwf_pkg.sv
package gwf_pkg;

  // Width needed to hold a count from 0 up to and including n.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_RISE = 2'd1,
    DEC_FALL = 2'd2
  } decision_e;

endpackage

// File: rtl/gwf_sample_window.sv
module gwf_sample_window #(
  parameter int WIN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_en_i,
  input  logic sample_i,
  output logic oldest_o,
  output logic [WIN-1:0] window_o
);

  logic [WIN-1:0] win_q;
  logic [WIN-1:0] win_d;

  always_comb begin
    win_d = win_q;
    if (shift_en_i) begin
      win_d = {win_q[WIN-2:0], sample_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '1;
    end else begin
      win_q <= win_d;
    end
  end

  assign oldest_o = win_q[WIN-1];
  assign window_o = win_q;

endmodule

// File: rtl/gwf_ones_tally.sv
module gwf_ones_tally #(
  parameter int WIN = 32,
  localparam int CW = gwf_pkg::count_width(WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tally_en_i,
  input  logic          enter_i,
  input  logic          leave_i,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] FULL = CW'(WIN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tally_en_i) begin
      if (enter_i && !leave_i) begin
        cnt_d = cnt_q + 1'b1;
      end else if (leave_i && !enter_i) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= FULL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
    (cnt_q + 1'b1 == $past(cnt_q)));

endmodule

// File: rtl/gwf_hyst_decide.sv
module gwf_hyst_decide #(
  parameter int WIN     = 32,
  parameter int RISE_TH = 24,
  parameter int FALL_TH = 8,
  localparam int CW = gwf_pkg::count_width(WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  output logic          level_o
);

  import gwf_pkg::*;

  localparam logic [CW-1:0] HI = CW'(RISE_TH);
  localparam logic [CW-1:0] LO = CW'(FALL_TH);

  decision_e dec;
  logic      lvl_q;
  logic      lvl_d;

  always_comb begin
    if (count_i >= HI) begin
      dec = DEC_RISE;
    end else if (count_i <= LO) begin
      dec = DEC_FALL;
    end else begin
      dec = DEC_HOLD;
    end
  end

  always_comb begin
    unique case (dec)
      DEC_RISE: lvl_d = 1'b1;
      DEC_FALL: lvl_d = 1'b0;
      default:  lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  // R5
  rise_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_q) |-> ($past(count_i) >= HI));

  // R6
  fall_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl_q) |-> ($past(count_i) <= LO));

  // R7
  band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((count_i > LO) && (count_i < HI)) |=> $stable(lvl_q));

endmodule

// File: rtl/glitch_window_filter.sv
module glitch_window_filter #(
  parameter int WIN     = 32,
  parameter int RISE_TH = 24,
  parameter int FALL_TH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     line_i,
  output logic                     level_o,
  output logic [$clog2(WIN+1)-1:0] ones_o
);

  localparam int CW = gwf_pkg::count_width(WIN);

  logic           advance;
  logic           oldest;
  logic [WIN-1:0] window;
  logic [CW-1:0]  count;

  assign advance = 1'b1;

  gwf_sample_window #(
    .WIN (WIN)
  ) i_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (advance),
    .sample_i   (line_i),
    .oldest_o   (oldest),
    .window_o   (window)
  );

  gwf_ones_tally #(
    .WIN (WIN)
  ) i_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tally_en_i (advance),
    .enter_i    (line_i),
    .leave_i    (oldest),
    .count_o    (count)
  );

  gwf_hyst_decide #(
    .WIN     (WIN),
    .RISE_TH (RISE_TH),
    .FALL_TH (FALL_TH)
  ) i_decide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count),
    .level_o (level_o)
  );

  assign ones_o = count;

  // R2
  tally_matches_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(window) == int'(count));

endmodule

// File: tb/test_glitch_window_filter.sv
`timescale 1ns/1ps
module test_glitch_window_filter;

  localparam int WIN = 32;
  localparam int RTH = 24;
  localparam int FTH = 8;
  localparam int CW  = $clog2(WIN + 1);
  localparam int SHORT_MAX = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line = 1'b1;
  logic          level;
  logic [CW-1:0] ones;

  int checks = 0;
  int fails  = 0;
  int trans  = 0;
  logic prev_lvl = 1'b1;

  logic [WIN-1:0] m_win;
  int             m_cnt;
  logic           m_lvl;

  always #2.5 clk = ~clk;

  glitch_window_filter #(
    .WIN     (WIN),
    .RISE_TH (RTH),
    .FALL_TH (FTH)
  ) i_glitch_window_filter (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .line_i  (line),
    .level_o (level),
    .ones_o  (ones)
  );

  function automatic logic next_level(input int c, input logic l);
    if (c >= RTH) return 1'b1;
    if (c <= FTH) return 1'b0;
    return l;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One sample: drive at the falling edge, the model advances with the rising edge,
  // then compare at the next falling edge.
  task automatic drive(input logic b);
    logic nl;
    line = b;
    @(posedge clk);
    nl    = next_level(m_cnt, m_lvl);
    m_cnt = m_cnt + int'(b) - int'(m_win[WIN-1]);
    m_win = {m_win[WIN-2:0], b};
    m_lvl = nl;
    @(negedge clk);
    check("R2 count", int'(ones), m_cnt);
    check("R5/R6/R7/R9 level", int'(level), int'(m_lvl));
    if (level !== prev_lvl) trans++;
    prev_lvl = level;
  endtask

  task automatic hold(input logic b, input int n);
    for (int i = 0; i < n; i++) drive(b);
  endtask

  // Edge to target level, a short random burst, then a stable level.
  task automatic short_edge(input logic tgt);
    int blen;
    int t0;
    t0   = trans;
    blen = 1 + int'($urandom_range(SHORT_MAX - 1));
    for (int i = 0; i < blen; i++) drive(($urandom_range(1) == 1) ? 1'b1 : 1'b0);
    hold(tgt, WIN + 8);
    check("R8 transitions per edge", trans - t0, 1);
    check("R8 final level", int'(level), int'(tgt));
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    m_win = '1;
    m_cnt = WIN;
    m_lvl = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    check("R1 reset level", int'(level), 1);
    check("R1 reset count", int'(ones), WIN);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 level after release", int'(level), 1);
    check("R1 count after release", int'(ones), WIN);

    // R3: idle high keeps the count at its maximum
    hold(1'b1, 40);
    check("R3 count at full", int'(ones), WIN);

    // R6 then R5: clean edges
    trans = 0;
    hold(1'b0, WIN + 8);
    check("R6 clean fall transitions", trans, 1);
    check("R6 clean fall count", int'(ones), 0);
    trans = 0;
    hold(1'b1, WIN + 8);
    check("R5 clean rise transitions", trans, 1);

    // R7: alternating pattern keeps the count at 16, level stays high
    for (int i = 0; i < 64; i++) drive(i[0]);
    check("R7 hold high in band", int'(level), 1);
    hold(1'b0, WIN + 4);
    for (int i = 0; i < 64; i++) drive(i[0]);
    check("R7 hold low in band", int'(level), 0);

    // Late glitch inside a run of ones after a fall to zero
    hold(1'b0, WIN + 4);
    trans = 0;
    drive(1'b0);
    hold(1'b1, 7);
    drive(1'b0);
    hold(1'b1, WIN + 8);
    check("R8 late glitch single rise", trans, 1);

    // R8: random short bursts around edges in both directions
    for (int k = 0; k < 12; k++) begin
      short_edge(1'b0);
      short_edge(1'b1);
    end

    // R9: long random bursts, model comparison only
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 80; i++) drive(($urandom_range(1) == 1) ? 1'b1 : 1'b0);
      hold(k[0], WIN + 4);
      check("R9 settled level", int'(level), int'(k[0]));
    end

    finish_up();
  end

endmodule